// File: doc/BRIEF.md
# E3 Loss-of-Frame Integrator and Remote Alarm Generator

This block sits behind an E3 receive framer. The framer gives it a raw out-of-frame result at each alignment check, and the block also takes the line loss-of-signal and alarm-indication-signal conditions. It keeps a registered out-of-frame (OOF) status and integrates it against a 1 ms tick. The result is a loss-of-frame (LOF) declaration whose window can be selected, including a mode that has no delay at all. Software can force one OOF at the next alignment check by giving a control bit a rising edge.

Under automatic alarm mode, the four conditions are gated and combined into the remote alarm (A) bit of the transmitted frame, which is refreshed once per frame. The LOF gate is an enable. The LOS, OOF and AIS gates are disables. The block also drives a registered data-enable flag for the outgoing payload, and that flag can mark overhead positions as overhead or let them through as data.

Top module: `e3_lof_alarm`

## Requirements
- R1: After a synchronous reset, `oof_out`, `lof_out`, `tx_a_bit` and `data_en` are all 0.
- R2: `lof_win` selects how many `tick_1ms` pulses OOF must last before LOF is declared: 2'b00 = 3 ticks, 2'b01 = 2 ticks, 2'b10 = 1 tick. A tick counts when `oof_out` is 1 in the cycle of the tick, and `lof_out` rises on the edge of the last counted tick.
- R3: With `lof_win` = 2'b11, `lof_out` rises and falls on the same clock edge as `oof_out`.
- R4: When `oof_out` returns to 0 before LOF is declared, the tick count restarts, so a new OOF episode again needs the full window.
- R5: A declared LOF clears once `oof_out` has been 0 for the same number of ticks as the selected window.
- R6: `lof_alm_en` = 1 lets LOF set the A bit. `lof_alm_en` = 0 makes LOF have no effect on it.
- R7: For LOS, OOF and AIS, a disable bit at 0 lets that condition set the A bit, and a disable bit at 1 makes the condition ignored.
- R8: `tx_a_bit` is loaded only on the edge where `frame_strobe` is 1. The value loaded is the OR of the gated conditions ANDed with `auto_rai`. Between strobes it holds.
- R9: `oof_out` changes only on an `align_chk` edge, where it takes `oof_raw`. A 0-to-1 transition of `force_resync` forces `oof_out` to 1 at the next alignment check, for exactly one check. Holding `force_resync` at 1 does not trigger again.
- R10: `data_en` is a one-cycle-delayed copy of the payload marking. With `oh_mask_dis` = 0, a cycle with `oh_pos` = 1 gives `data_en` = 0. With `oh_mask_dis` = 1, or with `oh_pos` = 0, it gives `data_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| align_chk | input | 1 | Alignment-check event from the framer |
| oof_raw | input | 1 | Framer reframing result, valid with `align_chk` |
| los_in | input | 1 | Loss-of-signal condition |
| ais_in | input | 1 | Alarm-indication-signal condition |
| frame_strobe | input | 1 | Once-per-frame pulse that refreshes the A bit |
| oh_pos | input | 1 | Current payload position is overhead |
| lof_win | input | 2 | LOF integration window select |
| lof_alm_en | input | 1 | Enable LOF into the A bit |
| los_alm_dis | input | 1 | Disable LOS into the A bit |
| oof_alm_dis | input | 1 | Disable OOF into the A bit |
| ais_alm_dis | input | 1 | Disable AIS into the A bit |
| auto_rai | input | 1 | Automatic remote alarm mode |
| force_resync | input | 1 | Rising edge forces one OOF |
| oh_mask_dis | input | 1 | 1 = overhead positions marked as data |
| oof_out | output | 1 | Registered out-of-frame status |
| lof_out | output | 1 | Loss-of-frame status |
| tx_a_bit | output | 1 | Transmit remote alarm bit |
| data_en | output | 1 | Registered payload data-enable |

## Verification
The assertions assume that `lof_win` stays fixed between resets. Without that, the immediate-mode equality of LOF and OOF could fail after the window is switched while a timed LOF is pending. The stimulus therefore changes `lof_win` only while reset is applied. It drives every strobe and tick as a single-cycle pulse and never puts a tick on the same edge as an alignment check, so each count boundary falls on one known edge.

// File: rtl/e3_lof_pkg.sv
package e3_lof_pkg;
  typedef enum logic [1:0] {
    WIN_LONG  = 2'b00,
    WIN_MID   = 2'b01,
    WIN_SHORT = 2'b10,
    WIN_NOW   = 2'b11
  } win_sel_t;

  localparam int NUM_SRC = 4;
  // source index: 0 = LOF, 1 = LOS, 2 = OOF, 3 = AIS
  localparam logic [NUM_SRC-1:0] GATE_IS_ENABLE = 4'b0001;
endpackage

// File: rtl/e3_resync_ctl.sv
module e3_resync_ctl (
  input  logic clk,
  input  logic rst,
  input  logic align_chk,
  input  logic oof_raw,
  input  logic force_resync,
  output logic oof_nxt,
  output logic oof_q
);
  logic force_prev;
  logic pend_q;
  logic force_rise;
  logic force_now;

  assign force_rise = force_resync & ~force_prev;
  assign force_now  = pend_q | force_rise;

  always_comb begin
    oof_nxt = oof_q;
    if (align_chk) oof_nxt = force_now | oof_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_prev <= 1'b0;
      pend_q     <= 1'b0;
      oof_q      <= 1'b0;
    end else begin
      force_prev <= force_resync;
      pend_q     <= force_now & ~align_chk;
      oof_q      <= oof_nxt;
    end
  end
endmodule

// File: rtl/e3_lof_integ.sv
module e3_lof_integ
  import e3_lof_pkg::*;
#(
  parameter int TICKS_LONG  = 3,
  parameter int TICKS_MID   = 2,
  parameter int TICKS_SHORT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1ms,
  input  logic [1:0] lof_win,
  input  logic       oof_nxt,
  input  logic       oof_q,
  output logic       lof_q
);
  localparam int CNT_W = $clog2(TICKS_LONG + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             mismatch;
  logic             now_mode;

  always_comb begin
    case (win_sel_t'(lof_win))
      WIN_LONG:  lim = CNT_W'(TICKS_LONG);
      WIN_MID:   lim = CNT_W'(TICKS_MID);
      WIN_SHORT: lim = CNT_W'(TICKS_SHORT);
      default:   lim = '0;
    endcase
  end

  assign now_mode = (win_sel_t'(lof_win) == WIN_NOW);
  assign mismatch = oof_q ^ lof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lof_q <= 1'b0;
    end else if (now_mode) begin
      cnt_q <= '0;
      lof_q <= oof_nxt;
    end else if (!mismatch) begin
      cnt_q <= '0;
    end else if (tick_1ms) begin
      if (cnt_q + 1'b1 >= lim) begin
        cnt_q <= '0;
        lof_q <= oof_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e3_rai_gen.sv
module e3_rai_gen
  import e3_lof_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_strobe,
  input  logic               auto_rai,
  input  logic [NUM_SRC-1:0] cond,
  input  logic [NUM_SRC-1:0] gate,
  output logic               a_bit
);
  logic [NUM_SRC-1:0] pass;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    if (GATE_IS_ENABLE[i]) begin : g_en
      assign pass[i] = cond[i] & gate[i];
    end else begin : g_dis
      assign pass[i] = cond[i] & ~gate[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) a_bit <= 1'b0;
    else if (frame_strobe) a_bit <= auto_rai & (|pass);
  end
endmodule

// File: rtl/e3_oh_mask.sv
module e3_oh_mask (
  input  logic clk,
  input  logic rst,
  input  logic oh_pos,
  input  logic oh_mask_dis,
  output logic data_en
);
  always_ff @(posedge clk) begin
    if (rst) data_en <= 1'b0;
    else     data_en <= ~(oh_pos & ~oh_mask_dis);
  end
endmodule

// File: rtl/e3_lof_alarm.sv
module e3_lof_alarm
  import e3_lof_pkg::*;
#(
  parameter int TICKS_LONG  = 3,
  parameter int TICKS_MID   = 2,
  parameter int TICKS_SHORT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1ms,
  input  logic       align_chk,
  input  logic       oof_raw,
  input  logic       los_in,
  input  logic       ais_in,
  input  logic       frame_strobe,
  input  logic       oh_pos,
  input  logic [1:0] lof_win,
  input  logic       lof_alm_en,
  input  logic       los_alm_dis,
  input  logic       oof_alm_dis,
  input  logic       ais_alm_dis,
  input  logic       auto_rai,
  input  logic       force_resync,
  input  logic       oh_mask_dis,
  output logic       oof_out,
  output logic       lof_out,
  output logic       tx_a_bit,
  output logic       data_en
);
  logic oof_nxt;

  e3_resync_ctl u_resync (
    .clk(clk), .rst(rst), .align_chk(align_chk), .oof_raw(oof_raw),
    .force_resync(force_resync), .oof_nxt(oof_nxt), .oof_q(oof_out)
  );

  e3_lof_integ #(
    .TICKS_LONG(TICKS_LONG), .TICKS_MID(TICKS_MID), .TICKS_SHORT(TICKS_SHORT)
  ) u_integ (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .lof_win(lof_win),
    .oof_nxt(oof_nxt), .oof_q(oof_out), .lof_q(lof_out)
  );

  e3_rai_gen u_rai (
    .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .auto_rai(auto_rai),
    .cond({ais_in, oof_out, los_in, lof_out}),
    .gate({ais_alm_dis, oof_alm_dis, los_alm_dis, lof_alm_en}),
    .a_bit(tx_a_bit)
  );

  e3_oh_mask u_ohm (
    .clk(clk), .rst(rst), .oh_pos(oh_pos), .oh_mask_dis(oh_mask_dis),
    .data_en(data_en)
  );
endmodule

// File: rtl/e3_lof_alarm_chk.sv
module e3_lof_alarm_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1ms,
  input logic       align_chk,
  input logic       oof_raw,
  input logic       frame_strobe,
  input logic       oh_pos,
  input logic [1:0] lof_win,
  input logic       auto_rai,
  input logic       force_resync,
  input logic       oh_mask_dis,
  input logic       oof_out,
  input logic       lof_out,
  input logic       tx_a_bit,
  input logic       data_en
);
  assert_timed_change_R2: assert property (@(posedge clk) disable iff (rst)
    (lof_win != 2'b11) && !tick_1ms |=> lof_out == $past(lof_out));

  assert_immediate_R3: assert property (@(posedge clk) disable iff (rst)
    (lof_win == 2'b11) |-> lof_out == oof_out);

  assert_a_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe |=> $stable(tx_a_bit));

  assert_auto_off_R8: assert property (@(posedge clk) disable iff (rst)
    frame_strobe && !auto_rai |=> !tx_a_bit);

  assert_oof_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !align_chk |=> $stable(oof_out));

  assert_oof_follow_R9: assert property (@(posedge clk) disable iff (rst)
    align_chk && oof_raw |=> oof_out);

  assert_force_R9: assert property (@(posedge clk) disable iff (rst)
    align_chk && $rose(force_resync) |=> oof_out);

  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    oh_pos && !oh_mask_dis |=> !data_en);

  assert_pass_R10: assert property (@(posedge clk) disable iff (rst)
    !oh_pos || oh_mask_dis |=> data_en);
endmodule

bind e3_lof_alarm e3_lof_alarm_chk u_chk (
  .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .align_chk(align_chk),
  .oof_raw(oof_raw), .frame_strobe(frame_strobe), .oh_pos(oh_pos),
  .lof_win(lof_win), .auto_rai(auto_rai), .force_resync(force_resync),
  .oh_mask_dis(oh_mask_dis), .oof_out(oof_out), .lof_out(lof_out),
  .tx_a_bit(tx_a_bit), .data_en(data_en)
);

// File: tb/e3_lof_alarm_bench.sv
`timescale 1ns/1ps
module e3_lof_alarm_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1ms = 0, align_chk = 0, oof_raw = 0, los_in = 0, ais_in = 0;
  logic frame_strobe = 0, oh_pos = 0;
  logic [1:0] lof_win = 2'b00;
  logic lof_alm_en = 0, los_alm_dis = 1, oof_alm_dis = 1, ais_alm_dis = 1;
  logic auto_rai = 0, force_resync = 0, oh_mask_dis = 0;
  logic oof_out, lof_out, tx_a_bit, data_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  e3_lof_alarm u_e3_lof_alarm (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .align_chk(align_chk),
    .oof_raw(oof_raw), .los_in(los_in), .ais_in(ais_in),
    .frame_strobe(frame_strobe), .oh_pos(oh_pos), .lof_win(lof_win),
    .lof_alm_en(lof_alm_en), .los_alm_dis(los_alm_dis),
    .oof_alm_dis(oof_alm_dis), .ais_alm_dis(ais_alm_dis),
    .auto_rai(auto_rai), .force_resync(force_resync),
    .oh_mask_dis(oh_mask_dis), .oof_out(oof_out), .lof_out(lof_out),
    .tx_a_bit(tx_a_bit), .data_en(data_en)
  );

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] win);
    rst = 1'b1;
    lof_win = win;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic pulse_align(logic raw);
    oof_raw = raw; align_chk = 1'b1; cyc(); align_chk = 1'b0; cyc(2);
  endtask

  task automatic pulse_tick();
    tick_1ms = 1'b1; cyc(); tick_1ms = 1'b0; cyc(2);
  endtask

  task automatic pulse_frame();
    frame_strobe = 1'b1; cyc(); frame_strobe = 1'b0; cyc();
  endtask

  task automatic t_reset_R1();
    do_reset(2'b00);
    chk("R1", "oof_out", oof_out, 1'b0);
    chk("R1", "lof_out", lof_out, 1'b0);
    chk("R1", "tx_a_bit", tx_a_bit, 1'b0);
    chk("R1", "data_en", data_en, 1'b0);
  endtask

  task automatic t_window_R2(logic [1:0] win, int n);
    do_reset(win);
    pulse_align(1'b1);
    chk("R2", "oof_out after check", oof_out, 1'b1);
    for (int i = 1; i < n; i++) begin
      pulse_tick();
      chk("R2", "lof_out before window end", lof_out, 1'b0);
    end
    pulse_tick();
    chk("R2", "lof_out at window end", lof_out, 1'b1);
    pulse_align(1'b0);
  endtask

  task automatic t_now_R3();
    do_reset(2'b11);
    oof_raw = 1'b1; align_chk = 1'b1; cyc(); align_chk = 1'b0;
    chk("R3", "lof_out same edge as oof", lof_out, 1'b1);
    chk("R3", "oof_out", oof_out, 1'b1);
    cyc();
    oof_raw = 1'b0; align_chk = 1'b1; cyc(); align_chk = 1'b0;
    chk("R3", "lof_out clears with oof", lof_out, 1'b0);
    cyc();
  endtask

  task automatic t_restart_R4_R5();
    do_reset(2'b00);
    pulse_align(1'b1);
    pulse_tick(); pulse_tick();
    pulse_align(1'b0);
    pulse_align(1'b1);
    pulse_tick(); pulse_tick();
    chk("R4", "lof_out after restart, 2 ticks", lof_out, 1'b0);
    pulse_tick();
    chk("R4", "lof_out after restart, 3 ticks", lof_out, 1'b1);
    pulse_align(1'b0);
    pulse_tick(); pulse_tick();
    chk("R5", "lof_out held, 2 clear ticks", lof_out, 1'b1);
    pulse_tick();
    chk("R5", "lof_out cleared, 3 clear ticks", lof_out, 1'b0);
  endtask

  task automatic t_gates_R6_R7_R8();
    do_reset(2'b11);
    auto_rai = 1'b1;
    lof_alm_en = 1'b0; los_alm_dis = 1'b1; oof_alm_dis = 1'b1; ais_alm_dis = 1'b1;
    pulse_align(1'b1);
    pulse_frame();
    chk("R6", "lof gate off", tx_a_bit, 1'b0);
    lof_alm_en = 1'b1; pulse_frame();
    chk("R6", "lof gate on", tx_a_bit, 1'b1);
    lof_alm_en = 1'b0; pulse_frame();
    chk("R7", "oof ignored when disabled", tx_a_bit, 1'b0);
    oof_alm_dis = 1'b0; pulse_frame();
    chk("R7", "oof passes when disable 0", tx_a_bit, 1'b1);
    oof_alm_dis = 1'b1;
    pulse_align(1'b0);
    los_in = 1'b1; pulse_frame();
    chk("R7", "los ignored when disabled", tx_a_bit, 1'b0);
    los_alm_dis = 1'b0; pulse_frame();
    chk("R7", "los passes when disable 0", tx_a_bit, 1'b1);
    los_in = 1'b0; los_alm_dis = 1'b1;
    ais_in = 1'b1; pulse_frame();
    chk("R7", "ais ignored when disabled", tx_a_bit, 1'b0);
    ais_alm_dis = 1'b0;
    cyc(3);
    chk("R8", "no update without strobe", tx_a_bit, 1'b0);
    pulse_frame();
    chk("R8", "ais passes at strobe", tx_a_bit, 1'b1);
    auto_rai = 1'b0; pulse_frame();
    chk("R8", "auto alarm off", tx_a_bit, 1'b0);
    ais_in = 1'b0; ais_alm_dis = 1'b1;
  endtask

  task automatic t_force_R9();
    do_reset(2'b00);
    oof_raw = 1'b0;
    force_resync = 1'b1; cyc(2);
    chk("R9", "no change before check", oof_out, 1'b0);
    pulse_align(1'b0);
    chk("R9", "forced oof", oof_out, 1'b1);
    pulse_align(1'b0);
    chk("R9", "one check only, held bit", oof_out, 1'b0);
    pulse_align(1'b0);
    chk("R9", "held bit does not retrigger", oof_out, 1'b0);
    force_resync = 1'b0; cyc(2); force_resync = 1'b1; cyc();
    pulse_align(1'b0);
    chk("R9", "second rising edge forces again", oof_out, 1'b1);
    force_resync = 1'b0;
    pulse_align(1'b0);
  endtask

  task automatic t_mask_R10();
    do_reset(2'b00);
    oh_mask_dis = 1'b0; oh_pos = 1'b1; cyc();
    chk("R10", "overhead masked", data_en, 1'b0);
    oh_pos = 1'b0; cyc();
    chk("R10", "payload as data", data_en, 1'b1);
    oh_pos = 1'b1; oh_mask_dis = 1'b1; cyc();
    chk("R10", "masking disabled", data_en, 1'b1);
    oh_pos = 1'b0; oh_mask_dis = 1'b0;
  endtask

  initial begin
    cyc(2);
    t_reset_R1();
    t_window_R2(2'b00, 3);
    t_window_R2(2'b01, 2);
    t_window_R2(2'b10, 1);
    t_now_R3();
    t_restart_R4_R5();
    t_gates_R6_R7_R8();
    t_force_R9();
    t_mask_R10();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule